// File: doc/BRIEF.md
# Fall-Through FIFO with Shift Handshake

This block is a single-clock first-in first-out buffer of 64 words, each 9 bits wide. It has no read or write enables. A producer raises a shift-in strobe to hand over a word, and the word then moves on its own toward an output stage. A consumer watches an output-ready flag and raises a shift-out strobe to take the word that is presented. An input-ready flag tells the producer whether there is room. Producers may also ignore that flag and burst words in, because a strobe that arrives while the buffer is full is simply dropped.

Both strobes are sampled on the system clock. A strobe acts once per assertion: holding it high does not repeat the action. A shift-out that is raised before any word is present stays armed. The first word to reach the output stage is then shown for one cycle and taken. An output-enable input floats the data outputs without touching the flags. A synchronous reset empties the buffer.

Top module: `ripple_fifo`

## Requirements
- R1: The buffer holds up to 64 words of 9 bits and delivers them at `dout` in the order in which they were accepted.
- R2: A word on `din` is accepted once for each low-to-high transition of `shift_in` seen at a clock edge; holding `shift_in` high stores no further copies.
- R3: `in_ready` is high while fewer than 64 words are held and low once 64 are held; a `shift_in` transition while 64 words are held is ignored and leaves the stored words unchanged.
- R4: When the buffer is empty, a word whose `shift_in` is first sampled high at clock edge N is at `dout` with `out_ready` high right after edge N+1, and not before.
- R5: While `out_ready` is high, the word stays at `dout` until `shift_out` is sampled high after having been low. That sample removes the word, and the next stored word is presented at the same edge. `shift_out` held high removes one word only.
- R6: If `shift_out` is already high and has removed no word, a word that reaches the empty output stage raises `out_ready` for exactly one cycle and is then removed. `out_ready` stays low afterwards until another word is stored.
- R7: While `rst` is high at a clock edge the buffer is emptied; afterwards `out_ready` is low, `in_ready` is high and no earlier word is delivered.
- R8: With `out_en` low, `dout` is high impedance and the flags are unchanged; with `out_en` high, `dout` shows the presented word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_in | input | 1 | Shift-in strobe, acts on its rising transition |
| din | input | 9 | Word to store |
| shift_out | input | 1 | Shift-out strobe, removes the presented word |
| out_en | input | 1 | Drives `dout` when high, floats it when low |
| dout | output | 9 | Presented word |
| in_ready | output | 1 | Room for at least one more word |
| out_ready | output | 1 | A valid word is presented at `dout` |

## Verification
The hardest condition to reach is a shift-in while all 64 places are full. At that point the output stage holds a word and the storage ring holds the other 63. The bench reaches it by pushing 64 patterned words without any shift-out and then strobing a 65th, distinct word. It then drains every word and compares each against the pattern, so a dropped, duplicated or overwritten entry shows up. The armed shift-out pulse is reached by raising shift-out on an empty buffer before the word arrives, and then sampling `out_ready` on each of the next three edges.

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_out,
  input  logic             out_en,
  output logic [WIDTH-1:0] dout,
  output logic             in_ready,
  output logic             out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    held;
  logic             out_valid, si_q, so_done;
  logic [WIDTH-1:0] out_data;

  wire accept   = shift_in & ~si_q & (held != FULL);
  wire pop      = shift_out & ~so_done & out_valid;
  wire ring_has = (held - CW'(out_valid)) != '0;
  wire load     = ring_has & (~out_valid | pop);

  always_ff @(posedge clk) begin
    if (accept) mem[wr_ptr] <= din;
    if (load) out_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      held      <= '0;
      out_valid <= 1'b0;
      si_q      <= 1'b0;
      so_done   <= 1'b0;
    end else begin
      si_q      <= shift_in;
      so_done   <= shift_out & (so_done | pop);
      out_valid <= load | (out_valid & ~pop);
      held      <= held + CW'(accept) - CW'(pop);
      if (accept) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (load)   rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
    end
  end

  assign in_ready  = held != FULL;
  assign out_ready = out_valid;
  assign dout      = out_en ? out_data : 'z;
endmodule

// File: rtl/ripple_fifo_chk.sv
module ripple_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          shift_in,
  input logic          shift_out,
  input logic          in_ready,
  input logic          out_ready,
  input logic [CW-1:0] held
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  logic si_prev;

  always_ff @(posedge clk) si_prev <= rst ? 1'b0 : shift_in;

  AST_RESET_EMPTY: assert property (@(posedge clk)
    $past(rst) |-> (!out_ready && in_ready && held == '0)); // R7

  AST_HELD_BOUND: assert property (@(posedge clk) disable iff (rst)
    held <= FULL); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !shift_out) |=> (!in_ready && held == FULL)); // R3

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (held == '0 && shift_in && !si_prev) |=> ##1 out_ready); // R4

  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !shift_out) |=> out_ready); // R5
endmodule

bind ripple_fifo ripple_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .shift_in(shift_in), .shift_out(shift_out),
  .in_ready(in_ready), .out_ready(out_ready), .held(held)
);

// File: tb/ripple_fifo_tb.sv
`timescale 1ns/1ps
module ripple_fifo_tb;
  logic clk = 1'b0, rst = 1'b1, shift_in = 1'b0, shift_out = 1'b0, out_en = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic in_ready, out_ready;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ripple_fifo u_dut (.clk(clk), .rst(rst), .shift_in(shift_in), .din(din),
    .shift_out(shift_out), .out_en(out_en), .dout(dout),
    .in_ready(in_ready), .out_ready(out_ready));

  function automatic logic [8:0] pat(int i);
    return 9'((i * 37 + 11) & 511);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [8:0] w);
    @(negedge clk); din = w; shift_in = 1'b1;
    @(negedge clk); shift_in = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); shift_out = 1'b1;
    @(negedge clk); shift_out = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; shift_in = 1'b0; shift_out = 1'b0; out_en = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_ready == 1'b0, "R7 out_ready after reset", out_ready, 0);
    check(in_ready == 1'b1, "R7 in_ready after reset", in_ready, 1);
  endtask

  task automatic t_latency();
    @(negedge clk); din = 9'h0A5; shift_in = 1'b1;
    @(posedge clk); #1;
    check(out_ready == 1'b0, "R4 not ready after first edge", out_ready, 0);
    @(posedge clk); #1;
    check(out_ready == 1'b1, "R4 ready after second edge", out_ready, 1);
    check(dout == 9'h0A5, "R4 word after second edge", dout, 9'h0A5);
    @(negedge clk); shift_in = 1'b0;
    pop();
    check(out_ready == 1'b0, "R5 empty after pop", out_ready, 0);
  endtask

  task automatic t_level_in();
    @(negedge clk); din = 9'h1C3; shift_in = 1'b1;
    repeat (6) @(negedge clk);
    shift_in = 1'b0;
    repeat (2) @(negedge clk);
    check(out_ready && dout == 9'h1C3, "R2 held strobe word", dout, 9'h1C3);
    pop();
    repeat (3) @(negedge clk);
    check(out_ready == 1'b0, "R2 single copy stored", out_ready, 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 64; i++) begin
      push(pat(i));
      if (i == 62) check(in_ready == 1'b1, "R3 ready with 63 held", in_ready, 1);
    end
    check(in_ready == 1'b0, "R3 not ready with 64 held", in_ready, 0);
    push(9'h1FF);
    check(in_ready == 1'b0, "R3 still full after extra strobe", in_ready, 0);
    check(dout == pat(0), "R3 head unchanged after extra strobe", dout, pat(0));
    for (int i = 0; i < 64; i++) begin
      check(out_ready && dout == pat(i), "R1 order on drain", dout, pat(i));
      pop();
      if (i == 0) check(in_ready == 1'b1, "R3 ready after one pop", in_ready, 1);
    end
    repeat (2) @(negedge clk);
    check(out_ready == 1'b0, "R3 extra word was dropped", out_ready, 0);
  endtask

  task automatic t_level_out();
    push(9'h011);
    push(9'h022);
    @(negedge clk); shift_out = 1'b1;
    repeat (4) @(negedge clk);
    shift_out = 1'b0;
    @(negedge clk);
    check(out_ready && dout == 9'h022, "R5 held shift_out pops one", dout, 9'h022);
    pop();
    check(out_ready == 1'b0, "R5 empty after second pop", out_ready, 0);
  endtask

  task automatic t_armed();
    @(negedge clk); shift_out = 1'b1;
    repeat (2) @(negedge clk);
    din = 9'h155; shift_in = 1'b1;
    @(posedge clk); #1;
    check(out_ready == 1'b0, "R6 not yet at output", out_ready, 0);
    @(posedge clk); #1;
    check(out_ready && dout == 9'h155, "R6 pulse shows word", dout, 9'h155);
    @(posedge clk); #1;
    check(out_ready == 1'b0, "R6 pulse ends after one cycle", out_ready, 0);
    @(negedge clk); shift_in = 1'b0; shift_out = 1'b0;
    repeat (3) @(negedge clk);
    check(out_ready == 1'b0, "R6 stays empty", out_ready, 0);
    check(in_ready == 1'b1, "R6 word consumed", in_ready, 1);
  endtask

  task automatic t_out_en();
    push(9'h1A5);
    @(negedge clk);
    out_en = 1'b0;
    #1;
    check(dout !== 9'h1A5 && (dout === 9'bz || dout === 9'h000), "R8 outputs floated", dout, 0);
    check(out_ready == 1'b1, "R8 flag kept while floated", out_ready, 1);
    @(negedge clk); out_en = 1'b1;
    #1;
    check(dout == 9'h1A5, "R8 outputs driven again", dout, 9'h1A5);
    pop();
  endtask

  task automatic t_reset_mid();
    push(9'h001); push(9'h002); push(9'h003);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(out_ready == 1'b0, "R7 empty after mid reset", out_ready, 0);
    check(in_ready == 1'b1, "R7 room after mid reset", in_ready, 1);
    push(9'h0F0);
    @(negedge clk);
    check(out_ready && dout == 9'h0F0, "R7 new word first after reset", dout, 9'h0F0);
    pop();
    check(out_ready == 1'b0, "R7 no old word after reset", out_ready, 0);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_level_in();
    t_fill_drain();
    t_level_out();
    t_armed();
    t_out_en();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule